// File: doc/BRIEF.md
# Addressed SPI Register Readback Interface

This block is the serial front end of a four-channel converter's register bank. A host on a shared SPI bus sends 24-bit frames, most significant bit first. Bit 23 marks a read (1) or a write (0). Bits 22:21 carry a device address, and bits 20:16 pick one of 27 readable registers. All SPI pins are oversampled in the system clock domain, so SCLK must be much slower than `clk`.

Readback is pipelined by one frame. A read frame fetches the chosen 16-bit register through a synchronous parallel read port. The fetched value is shifted out on SDO during the next frame, and that next frame is decoded as a new command at the same time. The host can therefore chain reads back to back. To collect only the last pending value, it sends the idle frame 0x1CE000 with its own device address in bits 22:21.

Several devices can share one bus. Each device compares the address in the frame with its strap input. A device that is not addressed ignores the frame and leaves SDO undriven for the following frame.

Top module: `spi_readback_if`

## Requirements
- R1: SDI is sampled on each falling SCLK edge while SYNC (`spi_cs_n`) is low, MSB first. SCLK idles high. In a frame, bit 23 = 1 means read, bits 22:21 are the device address and bits 20:16 are the register selector. In a read frame, bits 15:0 are ignored.
- R2: A committed read frame that matches the strap and has selector 0–26 produces exactly one single-cycle `rd_en` pulse, with `rd_addr` equal to the selector. `rd_data` is taken in the cycle after the pulse.
- R3: During the frame after a read, SDO carries the 24-bit word {8'h00, register value}, MSB first. Bit 23 is valid once SYNC falls, and each following bit is valid after the next rising SCLK edge. `spi_sdo_oe` is high for the whole frame.
- R4: A read with selector 27–31 makes no `rd_en` pulse, and the next frame's SDO word is all zeros with the output enabled.
- R5: A frame whose device address differs from `dev_addr` is ignored: it makes no `rd_en` pulse, and `spi_sdo_oe` stays low for the whole next frame.
- R6: A matching write frame, or the idle frame 0x1CE000 with the device address in bits 22:21, makes the next frame's SDO word all zeros with the output enabled.
- R7: A frame that ends with any SCLK falling-edge count other than 24 is discarded. It makes no `rd_en` pulse, and the next frame replays the response that was pending before it.
- R8: The frame that shifts out a response is itself decoded, so back-to-back reads each return the previous frame's register.
- R9: After reset, `rd_en` and `spi_sdo_oe` are low, and SDO stays undriven during the first frame.
- R10: While `spi_sdo_oe` is low, `spi_sdo` is 0. `spi_sdo_oe` is low whenever SYNC is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| dev_addr | input | 2 | Strap giving this device's bus address |
| spi_sclk | input | 1 | SPI serial clock, idles high |
| spi_cs_n | input | 1 | Frame select, active low |
| spi_sdi | input | 1 | Serial data from the host |
| spi_sdo | output | 1 | Serial data to the host |
| spi_sdo_oe | output | 1 | Output enable for the SDO pad driver |
| rd_en | output | 1 | Read strobe to the register bank |
| rd_addr | output | 5 | Register selector for the read |
| rd_data | input | 16 | Register value, valid one cycle after `rd_en` |

## Verification
A result is due at one of two points.

- **Read strobe:** `rd_en` follows the end of a frame within a few clock cycles. The bench counts strobes over the gap after SYNC rises and checks the count and the captured address before starting the next frame.
- **SDO response:** this appears one whole frame later. The bench samples SDO and the output enable eight clocks after each rising SCLK edge and just before the falling edge, well past the three-register path from the pins. Each sample is compared against a reference model that it updates only after the frame that requested the value.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;

  typedef enum logic [1:0] {
    CMD_FOREIGN = 2'd0,
    CMD_READ    = 2'd1,
    CMD_IDLE    = 2'd2,
    CMD_WRITE   = 2'd3
  } cmd_e;

  localparam logic [23:0] IDLE_FRAME = 24'h1CE000;

endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[g]}};
      else     chain <= {chain[STAGES-2:0], din[g]};
    end
    assign dout[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/spi_rb_frame.sv
module spi_rb_frame #(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk_s,
  input  logic               cs_n_s,
  input  logic               sdi_s,
  output logic               sclk_rise,
  output logic               cs_fall,
  output logic               cs_rise,
  output logic               commit,
  output logic [FRAME_W-1:0] frame_q
);

  localparam int CNT_MAX = FRAME_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic               sclk_d, cs_d;
  logic               sclk_fall;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] shreg;

  assign sclk_fall = sclk_d & ~sclk_s;
  assign sclk_rise = ~sclk_d & sclk_s;
  assign cs_fall   = cs_d & ~cs_n_s;
  assign cs_rise   = ~cs_d & cs_n_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d  <= 1'b1;
      cs_d    <= 1'b1;
      cnt     <= '0;
      shreg   <= '0;
      commit  <= 1'b0;
      frame_q <= '0;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_n_s;
      commit <= 1'b0;
      if (cs_fall) begin
        cnt <= '0;
      end else if (!cs_n_s && sclk_fall) begin
        shreg <= {shreg[FRAME_W-2:0], sdi_s};
        if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
      end
      if (cs_rise) begin
        commit  <= (cnt == CNT_W'(FRAME_W));
        frame_q <= shreg;
      end
    end
  end

  // R7: a commit is a one-cycle event tied to the end of a frame
  assert_commit_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    commit |=> !commit);
  assert_commit_on_cs_rise_R7: assert property (@(posedge clk) disable iff (rst)
    commit |-> $past(cs_rise));

endmodule

// File: rtl/spi_rb_resp.sv
module spi_rb_resp
  import spi_rb_pkg::*;
#(
  parameter int FRAME_W  = 24,
  parameter int DATA_W   = 16,
  parameter int SEL_W    = 5,
  parameter int DEV_W    = 2,
  parameter int NUM_REGS = 27,
  parameter logic [FRAME_W-1:0] IDLE_CODE = IDLE_FRAME
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               commit,
  input  logic [FRAME_W-1:0] frame_q,
  input  logic [DEV_W-1:0]   dev_addr,
  output logic               rd_en,
  output logic [SEL_W-1:0]   rd_addr,
  input  logic [DATA_W-1:0]  rd_data,
  output logic [DATA_W-1:0]  resp_data,
  output logic               resp_oe
);

  localparam int RW_BIT  = FRAME_W - 1;
  localparam int DEV_LSB = RW_BIT - DEV_W;
  localparam int SEL_LSB = DEV_LSB - SEL_W;
  localparam logic [SEL_W-1:0] SEL_LIMIT = SEL_W'(NUM_REGS);

  logic [DEV_W-1:0] f_dev;
  logic [SEL_W-1:0] f_sel;
  logic             f_idle;
  cmd_e             cmd;
  logic             capture;

  assign f_dev  = frame_q[RW_BIT-1:DEV_LSB];
  assign f_sel  = frame_q[DEV_LSB-1:SEL_LSB];
  assign f_idle = (frame_q[DEV_LSB-1:0] == IDLE_CODE[DEV_LSB-1:0]);

  always_comb begin
    if (f_dev != dev_addr)    cmd = CMD_FOREIGN;
    else if (frame_q[RW_BIT]) cmd = CMD_READ;
    else if (f_idle)          cmd = CMD_IDLE;
    else                      cmd = CMD_WRITE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en     <= 1'b0;
      rd_addr   <= '0;
      capture   <= 1'b0;
      resp_data <= '0;
      resp_oe   <= 1'b0;
    end else begin
      rd_en   <= 1'b0;
      capture <= rd_en;
      if (commit) begin
        resp_data <= '0;
        case (cmd)
          CMD_FOREIGN: resp_oe <= 1'b0;
          CMD_READ: begin
            resp_oe <= 1'b1;
            if (f_sel < SEL_LIMIT) begin
              rd_en   <= 1'b1;
              rd_addr <= f_sel;
            end
          end
          default: resp_oe <= 1'b1;
        endcase
      end
      if (capture) resp_data <= rd_data;
    end
  end

  assert_rd_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !rd_en);
  assert_rd_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (rd_addr < SEL_LIMIT));
  assert_foreign_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (commit && f_dev != dev_addr) |=> (!resp_oe && !rd_en));

endmodule

// File: rtl/spi_rb_tx.sv
module spi_rb_tx #(
  parameter int FRAME_W = 24,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sclk_rise,
  input  logic [DATA_W-1:0] resp_data,
  input  logic              resp_oe,
  output logic              sdo,
  output logic              sdo_oe
);

  localparam int PAD_W = FRAME_W - DATA_W;

  logic [FRAME_W-1:0] tx;
  logic [FRAME_W-1:0] word;

  assign word = resp_oe ? {{PAD_W{1'b0}}, resp_data} : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx     <= '0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else if (cs_fall) begin
      tx     <= word;
      sdo    <= word[FRAME_W-1];
      sdo_oe <= resp_oe;
    end else if (cs_rise) begin
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else if (!cs_n_s && sclk_rise) begin
      tx  <= {tx[FRAME_W-2:0], 1'b0};
      sdo <= sdo_oe & tx[FRAME_W-2];
    end
  end

  assert_sdo_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !sdo_oe |-> !sdo);
  assert_oe_drop_R10: assert property (@(posedge clk) disable iff (rst)
    cs_rise |=> !sdo_oe);
  assert_oe_from_resp_R5: assert property (@(posedge clk) disable iff (rst)
    (cs_fall && !resp_oe) |=> !sdo_oe);

endmodule

// File: rtl/spi_readback_if.sv
module spi_readback_if #(
  parameter int FRAME_W     = 24,
  parameter int DATA_W      = 16,
  parameter int SEL_W       = 5,
  parameter int DEV_W       = 2,
  parameter int NUM_REGS    = 27,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DEV_W-1:0]  dev_addr,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_sdi,
  output logic              spi_sdo,
  output logic              spi_sdo_oe,
  output logic              rd_en,
  output logic [SEL_W-1:0]  rd_addr,
  input  logic [DATA_W-1:0] rd_data
);

  logic [2:0]         pins_s;
  logic               sclk_rise, cs_fall, cs_rise, commit;
  logic [FRAME_W-1:0] frame_q;
  logic [DATA_W-1:0]  resp_data;
  logic               resp_oe;

  spi_rb_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst(rst),
    .din({spi_sclk, spi_cs_n, spi_sdi}),
    .dout(pins_s)
  );

  spi_rb_frame #(.FRAME_W(FRAME_W)) u_frame (
    .clk(clk), .rst(rst),
    .sclk_s(pins_s[2]), .cs_n_s(pins_s[1]), .sdi_s(pins_s[0]),
    .sclk_rise(sclk_rise), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .commit(commit), .frame_q(frame_q)
  );

  spi_rb_resp #(
    .FRAME_W(FRAME_W), .DATA_W(DATA_W), .SEL_W(SEL_W),
    .DEV_W(DEV_W), .NUM_REGS(NUM_REGS)
  ) u_resp (
    .clk(clk), .rst(rst),
    .commit(commit), .frame_q(frame_q), .dev_addr(dev_addr),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .resp_data(resp_data), .resp_oe(resp_oe)
  );

  spi_rb_tx #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst),
    .cs_n_s(pins_s[1]), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_rise(sclk_rise),
    .resp_data(resp_data), .resp_oe(resp_oe),
    .sdo(spi_sdo), .sdo_oe(spi_sdo_oe)
  );

endmodule

// File: tb/tb_spi_readback_if.sv
`timescale 1ns/1ps
module tb_spi_readback_if;

  localparam int HALF = 8;
  localparam int GAP  = 16;
  localparam logic [1:0] MY_DEV = 2'd1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  dev_addr = MY_DEV;
  logic        spi_sclk = 1'b1, spi_cs_n = 1'b1, spi_sdi = 1'b0;
  logic        spi_sdo, spi_sdo_oe, rd_en;
  logic [4:0]  rd_addr;
  logic [15:0] rd_data = '0;

  logic [15:0] regs [27];
  int          rd_cnt = 0;
  logic [4:0]  rd_last = '0;

  int checks = 0, fails = 0;
  logic        exp_oe = 1'b0;
  logic [15:0] exp_data = '0;
  string       prev_tag = "R9";
  bit          done = 0;

  always #2.5 clk = ~clk;

  spi_readback_if dut (
    .clk(clk), .rst(rst), .dev_addr(dev_addr),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_sdi(spi_sdi),
    .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always @(posedge clk) begin
    if (rd_en) begin
      rd_data <= regs[rd_addr];
      rd_cnt  <= rd_cnt + 1;
      rd_last <= rd_addr;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic string classify(input logic [23:0] f);
    if (f[22:21] != MY_DEV) return "R5";
    if (f[23]) return (f[20:16] < 5'd27) ? "R3" : "R4";
    return "R6";
  endfunction

  // Sends one frame with nbits clocks, checks the previous response and the read strobe.
  task automatic xfer(input logic [23:0] f, input int nbits);
    logic [23:0] cap = '0;
    bit          oe_bad = 0;
    int          cnt0 = rd_cnt;
    bit          want_rd;
    string       tag = (nbits == 24) ? classify(f) : "R7";
    spi_cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      spi_sdi = (i < 24) ? f[23-i] : 1'b0;
      wait_clk(HALF);
      if (i < 24) cap[23-i] = spi_sdo;
      if (spi_sdo_oe !== exp_oe) oe_bad = 1;
      spi_sclk = 1'b0;
      wait_clk(HALF);
      spi_sclk = 1'b1;
    end
    wait_clk(HALF);
    spi_cs_n = 1'b1;
    spi_sdi  = 1'b0;
    wait_clk(GAP);
    if (nbits >= 24) check({prev_tag, " R8 sdo word"}, {8'h0, cap}, {16'h0, exp_oe ? exp_data : 16'h0});
    check({prev_tag, " R10 sdo_oe"}, {31'h0, oe_bad}, 32'h0);
    check({prev_tag, " R10 idle oe"}, {31'h0, spi_sdo_oe}, 32'h0);
    want_rd = (nbits == 24) && f[23] && f[22:21] == MY_DEV && f[20:16] < 5'd27;
    check({tag, " R2 rd_en count"}, rd_cnt - cnt0, want_rd ? 1 : 0);
    if (want_rd) check("R2 R1 rd_addr", {27'h0, rd_last}, {27'h0, f[20:16]});
    if (nbits == 24) begin
      if (f[22:21] != MY_DEV) begin
        exp_oe = 1'b0; exp_data = '0;
      end else if (f[23]) begin
        exp_oe = 1'b1; exp_data = (f[20:16] < 5'd27) ? regs[f[20:16]] : 16'h0;
      end else begin
        exp_oe = 1'b1; exp_data = '0;
      end
    end
    prev_tag = tag;
  endtask

  initial begin
    void'($urandom(32'h5A17));
    for (int i = 0; i < 27; i++) regs[i] = 16'($urandom());
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);
    check("R9 reset oe", {31'h0, spi_sdo_oe}, 32'h0);
    check("R9 reset rd_en", {31'h0, rd_en}, 32'h0);
    check("R10 reset sdo", {31'h0, spi_sdo}, 32'h0);
    // directed: read gain A of device 1 then idle frame clocks it out (R1 R3)
    xfer(24'hA80000, 24);
    xfer(24'h3CE000, 24);
    // back-to-back reads with don't-care low bits (R8 R1)
    xfer(24'hA3FFFF, 24);
    xfer(24'hBA1234, 24);
    // out-of-range selectors (R4)
    xfer(24'hBB0000, 24);
    xfer(24'hBF0000, 24);
    // abort short and long, then replay (R7)
    xfer(24'hA50000, 24);
    xfer(24'hA20000, 10);
    xfer(24'hA20000, 25);
    xfer(24'h3CE000, 24);
    // foreign device read, then write frame (R5 R6)
    xfer(24'hC10000, 24);
    xfer(24'h215555, 24);
    xfer(24'hA00000, 24);
    // constrained random mix
    for (int n = 0; n < 140; n++) begin
      logic [23:0] f;
      int          r = $urandom_range(0, 99);
      logic [1:0]  dv = (r < 75) ? MY_DEV : 2'($urandom_range(0, 3));
      f = {1'b1, dv, 5'($urandom_range(0, 28)), 16'($urandom())};
      if (r % 10 == 0) f = {1'b0, dv, 21'h1CE000};
      else if (r % 10 == 1) f[23] = 1'b0;
      if (r % 17 == 3) xfer(f, 24 + (($urandom_range(0, 1) == 0) ? -3 : 2));
      else xfer(f, 24);
    end
    xfer(24'h3CE000, 24);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule